// File: doc/BRIEF.md
# System Control Register Block

This block is the reset and power control register file of a small dual-core subsystem. It decodes a 4 KB window on a simple strobe bus. Writes take effect at the clock edge that samples the write strobe. Read data and the error flag are registered and appear one cycle after the strobe.

Software uses it for several jobs:
- read back why the last reset happened, and choose which reset causes are masked;
- keep a word across warm resets;
- set where each core fetches its secure vector table after its next reset;
- hold cores in wait and release them;
- set and clear secure-debug bits;
- request a whole-system reset.

A set of extended registers exists only on the later variant. These are the security control word, two clock divider words, a clock force word, the second core's vector offset, an NMI enable, and five power-domain sense words. The variant is selected when the top nibble of a version parameter is 2 and the `ext_en` input is high. A read-only identification window at the top of the map returns one byte per word.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the registers hold these values. The reset cause word reads 1. The system power sense word (0x200) reads 0x7F. The SRAM sense words read 0. The core wait word (0x118) reads CPUWAIT_RST. The two vector offsets read VTOR0_RST and VTOR1_RST. Every other stored word reads 0. All pulse outputs and `err` are low.
- R2: These storage words read back the last value written to them: reset cause 0x100, reset mask 0x104, retention 0x10C, core-0 vector 0x110, core wait 0x118 and wake control 0x120. When the variant is active, the same holds for security control 0x00C, main clock divider 0x010, system clock divider 0x014, clock force 0x018, core-1 vector 0x114, NMI enable 0x11C, system sense 0x200 and SRAM sense 0x20C/0x210/0x214/0x218. `rdata` carries the word in the cycle after `rd_en` and holds it until the next read.
- R3: The secure-debug status word at 0x000 is read-only. A write to 0x004 ORs the data into the status. A write to 0x008 clears each status bit that is written as 1.
- R4: A write to 0x108 with bit 9 set drives `sys_reset_req` high for exactly the next cycle. A write to 0x108 with bit 9 clear has no effect. Reading 0x108 returns 0.
- R5: A write to the core wait word drives `core_release[i]` high for one cycle (the cycle after the strobe) when bit i of the word changes from 1 to 0. It does not pulse for 0→0, 1→1 or 0→1.
- R6: `vtor0` and `vtor1` always show the current core-0 and core-1 vector words.
- R7: Words 0xFD0 to 0xFFC hold a 12-entry ID table, in this order: 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. The table sits in bits 7:0 of each word and the upper bits are zero. Writes to the table change nothing.
- R8: The variant is active only when VERSION[31:28] = 2 and `ext_en` = 1. When it is inactive, an access to any extended word is treated as unmapped and leaves its contents unchanged. The exception is NMI enable: it then reads 0 without error, and a write to it is rejected.
- R9: `size` selects the access width: 0 = byte, 1 = halfword, 2 or 3 = word. A narrow access uses bits 7:0 or 15:0 and fills the upper bits with zero, for both write data and read data. Address bits 1:0 are ignored.
- R10: `err` is high for exactly one cycle, the cycle after the strobe, for any of these accesses: an unmapped offset, a read of a write-only word (0x004, 0x008, 0x108), or a write to a read-only word (0x000 or the ID table). A read that flags an error returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Enables the extended registers when the version check passes |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 12 | Byte offset in the 4 KB window |
| size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle access error flag |
| sys_reset_req | output | 1 | One-cycle system reset request |
| core_release | output | 2 | One-cycle power-up-and-reset pulse per core |
| vtor0 | output | 32 | Core-0 initial secure vector offset |
| vtor1 | output | 32 | Core-1 initial secure vector offset |

## Verification
The bench targets the edge cases of the core wait word. It writes 1→0, 0→0 and 0→1 patterns, and a release of both cores at once. A design that tests the new value instead of the falling edge would release a core that is already running, or release one on a rising edge. The secure-debug pair is driven with overlapping set and clear masks. This catches a clear port that stores or inverts instead of clearing, and a set port that overwrites. The bench also turns the variant off and then touches the extended words. A faulty gate would show up as a missing error, as a nonzero NMI read, or as a core-1 vector output that moves. Narrow writes and narrow reads expose any lane that is not zero-filled.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter logic [31:0] VERSION     = 32'h2004_1743,
  parameter logic [31:0] CPUWAIT_RST = 32'h0000_0003,
  parameter logic [31:0] VTOR0_RST   = 32'h1000_0000,
  parameter logic [31:0] VTOR1_RST   = 32'h1000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_en,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [11:0] addr,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        err,
  output logic        sys_reset_req,
  output logic [1:0]  core_release,
  output logic [31:0] vtor0,
  output logic [31:0] vtor1
);
  localparam bit EXT_OK = (VERSION[31:28] == 4'd2);
  localparam int NSRAM  = 4;

  localparam logic [11:0] A_DBG    = 12'h000;
  localparam logic [11:0] A_DBGSET = 12'h004;
  localparam logic [11:0] A_DBGCLR = 12'h008;
  localparam logic [11:0] A_SCSEC  = 12'h00C;
  localparam logic [11:0] A_FDIV   = 12'h010;
  localparam logic [11:0] A_SDIV   = 12'h014;
  localparam logic [11:0] A_CFRC   = 12'h018;
  localparam logic [11:0] A_SYN    = 12'h100;
  localparam logic [11:0] A_RMSK   = 12'h104;
  localparam logic [11:0] A_SWRST  = 12'h108;
  localparam logic [11:0] A_GRET   = 12'h10C;
  localparam logic [11:0] A_SV0    = 12'h110;
  localparam logic [11:0] A_SV1    = 12'h114;
  localparam logic [11:0] A_CPUW   = 12'h118;
  localparam logic [11:0] A_NMI    = 12'h11C;
  localparam logic [11:0] A_WIC    = 12'h120;
  localparam logic [11:0] A_PDSYS  = 12'h200;
  localparam logic [11:0] A_PD0    = 12'h20C;
  localparam logic [11:0] A_PD3    = 12'h218;
  localparam logic [11:0] A_ID0    = 12'hFD0;

  logic [31:0] secdbg, syndrome, rmask, gret, sv0, sv1, cpuwait, wic;
  logic [31:0] scsec, fdiv, sdiv, cfrc, nmi, pdsys;
  logic [31:0] pd_sram [NSRAM];

  logic        ext;
  logic [11:0] wa;
  logic [31:0] lane, wv, rv;
  logic        rbad, wbad, in_pd, in_id, unused_lo;
  logic [1:0]  pk;
  logic [3:0]  idk;

  assign ext       = EXT_OK && ext_en;
  assign wa        = {addr[11:2], 2'b00};
  assign unused_lo = ^addr[1:0];
  assign lane      = (size == 2'd0) ? 32'h0000_00FF :
                     (size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign wv        = wdata & lane;
  assign in_pd     = (wa >= A_PD0) && (wa <= A_PD3);
  assign in_id     = (wa >= A_ID0);
  assign pk        = 2'(wa[5:2] - 4'd3);
  assign idk       = wa[5:2] - 4'd4;
  assign vtor0     = sv0;
  assign vtor1     = sv1;

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    case (k)
      4'd0:    return 8'h04;
      4'd4:    return 8'h54;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h0B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    rv   = '0;
    rbad = 1'b0;
    wbad = 1'b0;
    case (wa)
      A_DBG:                     begin rv = secdbg; wbad = 1'b1; end
      A_DBGSET, A_DBGCLR, A_SWRST: rbad = 1'b1;
      A_SYN:                     rv = syndrome;
      A_RMSK:                    rv = rmask;
      A_GRET:                    rv = gret;
      A_SV0:                     rv = sv0;
      A_CPUW:                    rv = cpuwait;
      A_WIC:                     rv = wic;
      A_NMI:                     begin rv = ext ? nmi : '0; wbad = !ext; end
      A_SCSEC:                   if (ext) rv = scsec; else begin rbad = 1'b1; wbad = 1'b1; end
      A_FDIV:                    if (ext) rv = fdiv;  else begin rbad = 1'b1; wbad = 1'b1; end
      A_SDIV:                    if (ext) rv = sdiv;  else begin rbad = 1'b1; wbad = 1'b1; end
      A_CFRC:                    if (ext) rv = cfrc;  else begin rbad = 1'b1; wbad = 1'b1; end
      A_SV1:                     if (ext) rv = sv1;   else begin rbad = 1'b1; wbad = 1'b1; end
      A_PDSYS:                   if (ext) rv = pdsys; else begin rbad = 1'b1; wbad = 1'b1; end
      default: begin
        if (in_id) begin
          rv   = {24'd0, id_byte(idk)};
          wbad = 1'b1;
        end else if (in_pd && ext) begin
          rv = pd_sram[pk];
        end else begin
          rbad = 1'b1;
          wbad = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata         <= '0;
      err           <= 1'b0;
      sys_reset_req <= 1'b0;
      core_release  <= '0;
      secdbg        <= '0;
      syndrome      <= 32'd1;
      rmask         <= '0;
      gret          <= '0;
      sv0           <= VTOR0_RST;
      sv1           <= VTOR1_RST;
      cpuwait       <= CPUWAIT_RST;
      wic           <= '0;
      scsec         <= '0;
      fdiv          <= '0;
      sdiv          <= '0;
      cfrc          <= '0;
      nmi           <= '0;
      pdsys         <= 32'h7F;
      for (int i = 0; i < NSRAM; i++) pd_sram[i] <= '0;
    end else begin
      err           <= (rd_en && rbad) || (wr_en && wbad);
      sys_reset_req <= wr_en && (wa == A_SWRST) && wv[9];
      core_release  <= (wr_en && wa == A_CPUW) ? (cpuwait[1:0] & ~wv[1:0]) : 2'b00;
      if (rd_en) rdata <= rv & lane;
      if (wr_en && !wbad) begin
        case (wa)
          A_DBGSET: secdbg   <= secdbg | wv;
          A_DBGCLR: secdbg   <= secdbg & ~wv;
          A_SYN:    syndrome <= wv;
          A_RMSK:   rmask    <= wv;
          A_GRET:   gret     <= wv;
          A_SV0:    sv0      <= wv;
          A_SV1:    sv1      <= wv;
          A_CPUW:   cpuwait  <= wv;
          A_WIC:    wic      <= wv;
          A_NMI:    nmi      <= wv;
          A_SCSEC:  scsec    <= wv;
          A_FDIV:   fdiv     <= wv;
          A_SDIV:   sdiv     <= wv;
          A_CFRC:   cfrc     <= wv;
          A_PDSYS:  pdsys    <= wv;
          default:  if (in_pd) pd_sram[pk] <= wv;
        endcase
      end
    end
  end

  a_r5_release_leaves_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    core_release[0] |-> !cpuwait[0]);
  a_r5_release_leaves_bit1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    core_release[1] |-> !cpuwait[1]);
  a_r10_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(rd_en || wr_en));
  a_r10_bad_read_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (err && $past(rd_en) && !$past(wr_en)) |-> (rdata == 32'd0));
  a_r6_vtor0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(vtor0));
  a_r3_debug_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(secdbg));
  a_r4_reset_req_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(wr_en));
endmodule

// File: tb/sysctl_regs_bench.sv
`timescale 1ns/1ps
module sysctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_en = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  size = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, vtor0, vtor1;
  logic        err, sys_reset_req;
  logic [1:0]  core_release;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sysctl_regs u_sysctl_regs (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .size(size), .wdata(wdata), .rdata(rdata), .err(err),
    .sys_reset_req(sys_reset_req), .core_release(core_release),
    .vtor0(vtor0), .vtor1(vtor1)
  );

  // behavioural reference
  logic [31:0] m_dbg, m_syn, m_msk, m_gret, m_sv0, m_sv1, m_cw, m_wic;
  logic [31:0] m_scs, m_fd, m_sd, m_cf, m_nmi, m_pds;
  logic [31:0] m_sram [4];
  int id_tab [12] = '{'h04, 0, 0, 0, 'h54, 'hB8, 'h0B, 0, 'h0D, 'hF0, 'h05, 'hB1};
  logic [31:0] e_rdata;
  logic        e_err, e_sr;
  logic [1:0]  e_rel;

  function automatic logic [31:0] lanes(input logic [1:0] s);
    if (s == 0) return 32'hFF;
    if (s == 1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic void m_read(input int o, output logic [31:0] v, output logic bad);
    v = 0; bad = 0;
    if (o == 0) v = m_dbg;
    else if (o == 4 || o == 8 || o == 'h108) bad = 1;
    else if (o == 'h100) v = m_syn;
    else if (o == 'h104) v = m_msk;
    else if (o == 'h10C) v = m_gret;
    else if (o == 'h110) v = m_sv0;
    else if (o == 'h118) v = m_cw;
    else if (o == 'h120) v = m_wic;
    else if (o == 'h11C) v = ext_en ? m_nmi : 0;
    else if (o >= 'hFD0) v = id_tab[(o - 'hFD0) / 4];
    else if (ext_en && o == 'h00C) v = m_scs;
    else if (ext_en && o == 'h010) v = m_fd;
    else if (ext_en && o == 'h014) v = m_sd;
    else if (ext_en && o == 'h018) v = m_cf;
    else if (ext_en && o == 'h114) v = m_sv1;
    else if (ext_en && o == 'h200) v = m_pds;
    else if (ext_en && o >= 'h20C && o <= 'h218) v = m_sram[(o - 'h20C) / 4];
    else bad = 1;
  endfunction

  function automatic logic m_write(input int o, input logic [31:0] d);
    if (o == 4) m_dbg = m_dbg | d;
    else if (o == 8) m_dbg = m_dbg & ~d;
    else if (o == 'h108) ;
    else if (o == 'h100) m_syn = d;
    else if (o == 'h104) m_msk = d;
    else if (o == 'h10C) m_gret = d;
    else if (o == 'h110) m_sv0 = d;
    else if (o == 'h118) m_cw = d;
    else if (o == 'h120) m_wic = d;
    else if (ext_en && o == 'h11C) m_nmi = d;
    else if (ext_en && o == 'h00C) m_scs = d;
    else if (ext_en && o == 'h010) m_fd = d;
    else if (ext_en && o == 'h014) m_sd = d;
    else if (ext_en && o == 'h018) m_cf = d;
    else if (ext_en && o == 'h114) m_sv1 = d;
    else if (ext_en && o == 'h200) m_pds = d;
    else if (ext_en && o >= 'h20C && o <= 'h218) m_sram[(o - 'h20C) / 4] = d;
    else return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dbg = 0; m_syn = 1; m_msk = 0; m_gret = 0; m_sv0 = 32'h1000_0000;
      m_sv1 = 32'h1000_0000; m_cw = 3; m_wic = 0; m_scs = 0; m_fd = 0;
      m_sd = 0; m_cf = 0; m_nmi = 0; m_pds = 32'h7F;
      for (int i = 0; i < 4; i++) m_sram[i] = 0;
      e_rdata = 0; e_err = 0; e_sr = 0; e_rel = 0;
    end else begin
      automatic int o = int'(addr) & 'hFFC;
      automatic logic [31:0] d = wdata & lanes(size);
      automatic logic [31:0] v;
      automatic logic bad;
      e_err = 0; e_sr = 0; e_rel = 0;
      if (rd_en) begin
        m_read(o, v, bad);
        e_rdata = v & lanes(size);
        e_err = bad;
      end
      if (wr_en) begin
        if (o == 'h108) e_sr = d[9];
        if (o == 'h118) e_rel = m_cw[1:0] & ~d[1:0];
        if (m_write(o, d)) e_err = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 rdata vs model", rdata, e_rdata);
      chk("R10 err vs model", {31'd0, err}, {31'd0, e_err});
      chk("R4 sys_reset_req vs model", {31'd0, sys_reset_req}, {31'd0, e_sr});
      chk("R5 core_release vs model", {30'd0, core_release}, {30'd0, e_rel});
      chk("R6 vtor0 vs model", vtor0, m_sv0);
      chk("R6 vtor1 vs model", vtor1, m_sv1);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] s = 2'd2);
    @(negedge clk);
    addr = a; wdata = d; size = s; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; size = 2'd2;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v, input logic [1:0] s = 2'd2);
    @(negedge clk);
    addr = a; size = s; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; size = 2'd2;
    v = rdata;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp,
                      input logic exp_err = 1'b0, input logic [1:0] s = 2'd2);
    logic [31:0] v;
    rd(a, v, s);
    chk(tag, v, exp);
    chk(tag, {31'd0, err}, {31'd0, exp_err});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {sys_reset_req, core_release, err}, 32'd0);
    rst_n = 1'b1;
    // R1 reset values
    rchk("R1 syndrome", 12'h100, 32'd1);
    rchk("R1 sys sense", 12'h200, 32'h7F);
    rchk("R1 sram sense", 12'h214, 32'd0);
    rchk("R1 cpuwait", 12'h118, 32'd3);
    chk("R1 vtor0", vtor0, 32'h1000_0000);
    // R2 storage
    wr(12'h100, 32'hDEAD_BEEF); rchk("R2 syndrome", 12'h100, 32'hDEAD_BEEF);
    wr(12'h104, 32'h0000_5A5A); rchk("R2 mask", 12'h104, 32'h5A5A);
    wr(12'h10C, 32'hFFFF_FFFF); rchk("R2 retention", 12'h10C, 32'hFFFF_FFFF);
    wr(12'h120, 32'h1234_5678); rchk("R2 wake ctrl", 12'h120, 32'h1234_5678);
    wr(12'h010, 32'h0000_0007); rchk("R2 fclk div", 12'h010, 32'h7);
    wr(12'h018, 32'h8000_0001); rchk("R2 clock force", 12'h018, 32'h8000_0001);
    wr(12'h11C, 32'h1);         rchk("R2 nmi", 12'h11C, 32'h1);
    wr(12'h218, 32'hCAFE_0003); rchk("R2 sram3 sense", 12'h218, 32'hCAFE_0003);
    rchk("R2 sram2 untouched", 12'h214, 32'd0);
    // R3 secure debug
    wr(12'h004, 32'h0000_00F0); wr(12'h004, 32'h0000_0F00);
    rchk("R3 set ors", 12'h000, 32'h0000_0FF0);
    wr(12'h008, 32'h0000_0330);
    rchk("R3 w1c", 12'h000, 32'h0000_0CC0);
    rchk("R3 set port write-only", 12'h004, 32'd0, 1'b1);
    // R4 software reset
    wr(12'h108, 32'h0000_0200);
    chk("R4 pulse", {31'd0, sys_reset_req}, 32'd1);
    @(negedge clk); chk("R4 pulse one cycle", {31'd0, sys_reset_req}, 32'd0);
    wr(12'h108, 32'hFFFF_FDFF);
    chk("R4 other bits ignored", {31'd0, sys_reset_req}, 32'd0);
    rchk("R4 reads zero", 12'h108, 32'd0, 1'b1);
    // R5 core wait
    wr(12'h118, 32'h2); chk("R5 release core0", {30'd0, core_release}, 32'd1);
    wr(12'h118, 32'h0); chk("R5 release core1", {30'd0, core_release}, 32'd2);
    wr(12'h118, 32'h0); chk("R5 0->0 quiet", {30'd0, core_release}, 32'd0);
    wr(12'h118, 32'h3); chk("R5 0->1 quiet", {30'd0, core_release}, 32'd0);
    wr(12'h118, 32'h3); chk("R5 1->1 quiet", {30'd0, core_release}, 32'd0);
    wr(12'h118, 32'h0); chk("R5 both", {30'd0, core_release}, 32'd3);
    // R6 vector outputs
    wr(12'h110, 32'h0020_0000); chk("R6 vtor0", vtor0, 32'h0020_0000);
    wr(12'h114, 32'h0030_0400); chk("R6 vtor1", vtor1, 32'h0030_0400);
    // R7 ID window
    rchk("R7 first id", 12'hFD0, 32'h04);
    rchk("R7 pid0", 12'hFE0, 32'h54);
    rchk("R7 last id", 12'hFFC, 32'hB1);
    wr(12'hFE4, 32'hFFFF_FFFF);
    chk("R7 write flags", {31'd0, err}, 32'd1);
    rchk("R7 write ignored", 12'hFE4, 32'hB8);
    // R9 narrow
    wr(12'h10C, 32'hAABB_CCDD, 2'd0); rchk("R9 byte write", 12'h10C, 32'hDD);
    wr(12'h10E, 32'hAABB_CCDD, 2'd1); rchk("R9 half write", 12'h10C, 32'hCCDD);
    wr(12'h10C, 32'h1122_3344);
    rchk("R9 byte read", 12'h10D, 32'h44, 1'b0, 2'd0);
    rchk("R9 half read", 12'h10C, 32'h3344, 1'b0, 2'd1);
    // R10 unmapped and read-only
    rchk("R10 unmapped read", 12'h300, 32'd0, 1'b1);
    rchk("R10 gap read", 12'h01C, 32'd0, 1'b1);
    wr(12'h000, 32'hFFFF_FFFF); chk("R10 ro write", {31'd0, err}, 32'd1);
    @(negedge clk); chk("R10 err one cycle", {31'd0, err}, 32'd0);
    rchk("R10 ro unchanged", 12'h000, 32'h0000_0CC0);
    // R8 variant gate off
    @(negedge clk); ext_en = 1'b0;
    rchk("R8 ext absent", 12'h010, 32'd0, 1'b1);
    rchk("R8 nmi zero", 12'h11C, 32'd0, 1'b0);
    wr(12'h11C, 32'h1); chk("R8 nmi write rejected", {31'd0, err}, 32'd1);
    wr(12'h114, 32'h7777_0000); chk("R8 vtor1 kept", vtor1, 32'h0030_0400);
    rchk("R8 sense absent", 12'h200, 32'd0, 1'b1);
    @(negedge clk); ext_en = 1'b1;
    rchk("R8 nmi kept", 12'h11C, 32'h1);
    rchk("R8 fclk kept", 12'h010, 32'h7);
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule